// File: doc/BRIEF.md
# Operate Group-One Accumulator Unit

This block executes one class of register-only instruction words for a 12-bit accumulator machine. A word whose top four bits read `1110` carries eight independent enable bits. Together they clear, complement, increment and rotate the accumulator (AC) and its one-bit link companion. Several enables may be set in one word. They always take effect in a fixed staged order: clears, then complements, then the increment, then the rotation. The increment and the rotations treat link and AC as one 13-bit quantity, with the link as its most significant bit.

The sequencer presents the word, the current AC and the current link with a one-cycle strobe. One clock edge later the unit shows the new AC, the new link and a flag that marks the result as a valid group-one result. Words from any other class are not executed. When such a word arrives, the registered results keep their previous value and the flag stays low.

Top module: `g1op_unit`

## Requirements
- R1: The valid flag is high in the cycle after a strobed word whose bits [11:8] are `1110`. It is low in the cycle after any other word and after any cycle with no strobe.
- R2: A word outside group one, or a cycle with no strobe, leaves the AC and link outputs unchanged.
- R3: Bit 7 clears the AC and bit 6 clears the link. Both act before any other stage.
- R4: Bit 5 inverts the AC and bit 4 inverts the link. Both act after the clears, so bits 7 and 5 together give 7777 (octal).
- R5: Bit 0 adds one to the 13-bit link:AC value after the complements. A carry out of the AC therefore inverts the link.
- R6: Bit 3 rotates link:AC right by one place, and bit 2 rotates it left by one place, on the 13-bit ring. The rotation acts on the value left after the increment.
- R7: Bit 1 makes the selected rotation move two places. With neither rotate bit set, bit 1 has no effect.
- R8: With bits 3 and 2 both set, no rotation takes place.
- R9: A group-one word with bits [7:0] all zero returns the AC and link unchanged.
- R10: While reset is active, and after it, the AC, link and valid outputs read zero until the first group-one word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_strobe | input | 1 | Marks a word to execute in this cycle |
| op_word | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| acc_out | output | 12 | Resulting accumulator |
| link_out | output | 1 | Resulting link bit |
| res_valid | output | 1 | Result comes from a group-one word |

## Verification
Every result is due exactly one clock edge after the strobe. The AC, the link and the valid flag all pass through one register stage, and no other delay lies on the path. The bench drives inputs on the falling edge and lowers the strobe on the next falling edge. It compares the outputs at that same point, half a period after the registering edge. The hold checks then compare the outputs again one or more cycles later, with no strobe or with a word outside the group. Reset release passes through a two-flop synchronizer, so the bench waits several cycles after release before it sends its first word.

// File: rtl/g1op_pkg.sv
package g1op_pkg;

  // Bit index of each enable inside the word (LSB = 0).
  localparam int unsigned POS_CLR_ACC = 7;
  localparam int unsigned POS_CLR_LNK = 6;
  localparam int unsigned POS_INV_ACC = 5;
  localparam int unsigned POS_INV_LNK = 4;
  localparam int unsigned POS_ROT_R   = 3;
  localparam int unsigned POS_ROT_L   = 2;
  localparam int unsigned POS_ROT_TWO = 1;
  localparam int unsigned POS_INC     = 0;

  // Class code held in the four top bits of a group-one word.
  localparam logic [3:0] GROUP1_CODE = 4'b1110;

  typedef struct packed {
    logic clr_acc;
    logic clr_lnk;
    logic inv_acc;
    logic inv_lnk;
    logic rot_r;
    logic rot_l;
    logic rot_two;
    logic inc;
  } g1_ctl_t;

endpackage

// File: rtl/g1op_decode.sv
module g1op_decode
  import g1op_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_g1,
  output g1_ctl_t           ctl
);

  localparam int unsigned CLASS_LSB = WORD_W - 4;

  always_comb begin
    is_g1       = (word[WORD_W-1:CLASS_LSB] == GROUP1_CODE);
    ctl.clr_acc = word[POS_CLR_ACC];
    ctl.clr_lnk = word[POS_CLR_LNK];
    ctl.inv_acc = word[POS_INV_ACC];
    ctl.inv_lnk = word[POS_INV_LNK];
    ctl.rot_r   = word[POS_ROT_R];
    ctl.rot_l   = word[POS_ROT_L];
    ctl.rot_two = word[POS_ROT_TWO];
    ctl.inc     = word[POS_INC];
  end

endmodule

// File: rtl/g1op_arith.sv
module g1op_arith
  import g1op_pkg::*;
#(
  parameter int unsigned AC_W = 12
) (
  input  g1_ctl_t         ctl,
  input  logic [AC_W-1:0] acc_i,
  input  logic            lnk_i,
  output logic [AC_W:0]   ring_o
);

  logic [AC_W-1:0] acc_clr, acc_inv;
  logic            lnk_clr, lnk_inv;

  // Stage 1: clears.
  always_comb begin
    acc_clr = ctl.clr_acc ? '0 : acc_i;
    lnk_clr = ctl.clr_lnk ? 1'b0 : lnk_i;
  end

  // Stage 2: complements.
  always_comb begin
    acc_inv = ctl.inv_acc ? ~acc_clr : acc_clr;
    lnk_inv = ctl.inv_lnk ? ~lnk_clr : lnk_clr;
  end

  // Stage 3: increment across the joined link:AC value.
  always_comb begin
    ring_o = {lnk_inv, acc_inv};
    if (ctl.inc) ring_o = ring_o + {{AC_W{1'b0}}, 1'b1};
  end

endmodule

// File: rtl/g1op_rotate.sv
module g1op_rotate #(
  parameter int unsigned RING_W   = 13,
  parameter int unsigned MAX_STEP = 2
) (
  input  logic [RING_W-1:0] ring_i,
  input  logic              rot_r,
  input  logic              rot_l,
  input  logic              rot_two,
  output logic [RING_W-1:0] ring_o
);

  logic [RING_W-1:0] rr [MAX_STEP+1];
  logic [RING_W-1:0] rl [MAX_STEP+1];

  assign rr[0] = ring_i;
  assign rl[0] = ring_i;

  // Each step moves the ring by one more place than the last.
  for (genvar s = 1; s <= MAX_STEP; s++) begin : g_step
    assign rr[s] = {rr[s-1][0], rr[s-1][RING_W-1:1]};
    assign rl[s] = {rl[s-1][RING_W-2:0], rl[s-1][RING_W-1]};
  end

  always_comb begin
    unique case ({rot_r, rot_l})
      2'b10:   ring_o = rot_two ? rr[2] : rr[1];
      2'b01:   ring_o = rot_two ? rl[2] : rl[1];
      default: ring_o = ring_i;
    endcase
  end

endmodule

// File: rtl/g1op_unit.sv
module g1op_unit
  import g1op_pkg::*;
#(
  parameter int unsigned AC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_strobe,
  input  logic [AC_W-1:0] op_word,
  input  logic [AC_W-1:0] acc_in,
  input  logic            link_in,
  output logic [AC_W-1:0] acc_out,
  output logic            link_out,
  output logic            res_valid
);

  localparam int unsigned RING_W = AC_W + 1;

  // Reset: asserts at once, releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  g1_ctl_t           ctl;
  logic              is_g1;
  logic [RING_W-1:0] ring_pre, ring_post;

  g1op_decode #(.WORD_W(AC_W)) u_decode (
    .word  (op_word),
    .is_g1 (is_g1),
    .ctl   (ctl)
  );

  g1op_arith #(.AC_W(AC_W)) u_arith (
    .ctl    (ctl),
    .acc_i  (acc_in),
    .lnk_i  (link_in),
    .ring_o (ring_pre)
  );

  g1op_rotate #(.RING_W(RING_W), .MAX_STEP(2)) u_rotate (
    .ring_i  (ring_pre),
    .rot_r   (ctl.rot_r),
    .rot_l   (ctl.rot_l),
    .rot_two (ctl.rot_two),
    .ring_o  (ring_post)
  );

  // Next state
  logic              load_en;
  logic [AC_W-1:0]   acc_d;
  logic              lnk_d;
  logic              vld_d;
  logic [AC_W-1:0]   acc_q;
  logic              lnk_q;
  logic              vld_q;

  always_comb begin
    load_en = op_strobe & is_g1;
    vld_d   = load_en;
    acc_d   = acc_q;
    lnk_d   = lnk_q;
    if (load_en) begin
      acc_d = ring_post[AC_W-1:0];
      lnk_d = ring_post[AC_W];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_q <= '0;
      lnk_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      lnk_q <= lnk_d;
      vld_q <= vld_d;
    end
  end

  assign acc_out   = acc_q;
  assign link_out  = lnk_q;
  assign res_valid = vld_q;

  // Checks
  assert_valid_after_g1_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110) |=> res_valid);

  assert_no_valid_otherwise_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110) |=> !res_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110) |=> ($stable(acc_out) && $stable(link_out)));

  assert_clear_both_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110 && op_word[7:0] == 8'b1100_0000)
    |=> (acc_out == '0 && !link_out));

  assert_clear_invert_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110 && op_word[7:0] == 8'b1010_0000)
    |=> (acc_out == '1 && link_out == $past(link_in)));

  assert_rotate_keeps_ones_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110 && op_word[7:4] == 4'b0000 && !op_word[0])
    |=> ($countones({link_out, acc_out}) == $countones($past({link_in, acc_in}))));

  assert_noop_passes_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110 && op_word[7:0] == 8'h00)
    |=> (acc_out == $past(acc_in) && link_out == $past(link_in)));

  assert_dual_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_strobe && op_word[AC_W-1:AC_W-4] == 4'b1110 && op_word[7:0] == 8'b0000_1100)
    |=> (acc_out == $past(acc_in) && link_out == $past(link_in)));

  always_ff @(posedge clk) begin
    if (!rst_n_int) assert_reset_zero_R10: assert (acc_out == '0 && !link_out && !res_valid);
  end

endmodule

// File: tb/g1op_unit_bench.sv
module g1op_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_strobe = 1'b0;
  logic [11:0] op_word = '0;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] acc_out;
  logic        link_out;
  logic        res_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  g1op_unit u_g1op_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_strobe (op_strobe),
    .op_word   (op_word),
    .acc_in    (acc_in),
    .link_in   (link_in),
    .acc_out   (acc_out),
    .link_out  (link_out),
    .res_valid (res_valid)
  );

  // {word, acc, link, expected acc, expected link}
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {12'o7000, 12'o1234, 1'b1, 12'o1234, 1'b1},  // R9 no-op
    {12'o7200, 12'o5555, 1'b1, 12'o0000, 1'b1},  // R3 clear AC
    {12'o7300, 12'o7777, 1'b1, 12'o0000, 1'b0},  // R3 clear both
    {12'o7240, 12'o1234, 1'b0, 12'o7777, 1'b0},  // R4 clear then invert
    {12'o7120, 12'o0000, 1'b0, 12'o0000, 1'b1},  // R4 clear link then invert
    {12'o7001, 12'o7777, 1'b0, 12'o0000, 1'b1},  // R5 carry sets link
    {12'o7001, 12'o7777, 1'b1, 12'o0000, 1'b0},  // R5 carry clears link
    {12'o7041, 12'o0001, 1'b0, 12'o7777, 1'b0},  // R5 invert then increment
    {12'o7001, 12'o0017, 1'b1, 12'o0020, 1'b1},  // R5 plain increment
    {12'o7010, 12'o0001, 1'b0, 12'o0000, 1'b1},  // R6 right into link
    {12'o7004, 12'o4000, 1'b0, 12'o0000, 1'b1},  // R6 left into link
    {12'o7010, 12'o0000, 1'b1, 12'o4000, 1'b0},  // R6 link into AC msb
    {12'o7012, 12'o0003, 1'b0, 12'o4000, 1'b1},  // R7 double right
    {12'o7006, 12'o2000, 1'b0, 12'o0000, 1'b1},  // R7 double left
    {12'o7002, 12'o1234, 1'b0, 12'o1234, 1'b0},  // R7 double bit alone
    {12'o7014, 12'o1234, 1'b1, 12'o1234, 1'b1},  // R8 both rotates
    {12'o7301, 12'o0005, 1'b1, 12'o0001, 1'b0},  // R3 R5 clear then increment
    {12'o7031, 12'o7777, 1'b0, 12'o0000, 1'b0},  // R6 increment before rotate
    {12'o7025, 12'o3777, 1'b0, 12'o0001, 1'b1}   // R6 invert, inc, left
  };

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] w, input logic [11:0] a, input logic l);
    @(negedge clk);
    op_word   = w;
    acc_in    = a;
    link_in   = l;
    op_strobe = 1'b1;
    @(negedge clk);
    op_strobe = 1'b0;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", {link_out, acc_out}, 13'd0);
    chk("R10", {12'd0, res_valid}, 13'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", {link_out, acc_out}, 13'd0);
    chk("R10", {12'd0, res_valid}, 13'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][37:26], VEC[i][25:14], VEC[i][13]);
      chk($sformatf("vector %0d", i), {link_out, acc_out}, {VEC[i][0], VEC[i][12:1]});
      chk("R1", {12'd0, res_valid}, 13'd1);
    end

    // R1 R2: set a known result, then a word outside the group
    issue(12'o7240, 12'o0000, 1'b1);
    chk("R4", {link_out, acc_out}, {1'b1, 12'o7777});
    issue(12'o7400, 12'o0000, 1'b0);
    chk("R1", {12'd0, res_valid}, 13'd0);
    chk("R2", {link_out, acc_out}, {1'b1, 12'o7777});
    issue(12'o6201, 12'o1111, 1'b0);
    chk("R2", {link_out, acc_out}, {1'b1, 12'o7777});
    // R2: group-one word with no strobe
    @(negedge clk);
    op_word = 12'o7200; acc_in = 12'o0000; link_in = 1'b0;
    @(negedge clk);
    chk("R2", {link_out, acc_out}, {1'b1, 12'o7777});
    chk("R1", {12'd0, res_valid}, 13'd0);

    // R1: valid drops one cycle after a single strobe
    issue(12'o7001, 12'o0000, 1'b0);
    chk("R1", {12'd0, res_valid}, 13'd1);
    @(negedge clk);
    chk("R1", {12'd0, res_valid}, 13'd0);
    chk("R2", {link_out, acc_out}, {1'b0, 12'o0001});

    // R10: reset in the middle clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", {link_out, acc_out}, 13'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule